// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a full-duplex SPI master that a small processor core drives through three byte-wide registers: control, status and data. Software configures enable, master select, clock polarity, clock phase and a bit-rate code in the control register. A write to the data register loads the shift register and starts an 8-bit exchange. The byte leaves on MOSI, most significant bit first, while a byte from the slave is captured from MISO.

When the eighth bit has been exchanged, the received byte moves into a holding register and a completion flag is raised. Reads of the data register always return that holding register, never the live shift register. Two more flags report faults. One reports a write that collided with a transfer in progress. The other reports a mode fault, raised when another device pulls the slave-select input low while this block is master. The slave-select input can be switched off for single-master systems.

The register port is synchronous. A read strobe returns data on `reg_rdata` one clock later. Read and write strobes are never asserted in the same cycle.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control, status and receive holding registers read 0, and SCK is low.
- R2: Register addresses are control = 0, status = 1, data = 2. The read data for a read strobe appears on `reg_rdata` in the next cycle. Control bits are: enable at bit 6, slave-select disable at bit 5, master select at bit 4, clock polarity at bit 3, clock phase at bit 2, and rate code {bit 7, bit 1, bit 0}. Status bits are: transfer done at bit 7, write collision at bit 6, mode fault at bit 4; all other status bits read 0.
- R3: Rate code k in 0..6 gives an SCK half period of 2^k core clocks, so the divider is 2^(k+1). Code 7 is reserved and behaves as code 6. The rate code is latched when a transfer starts. While no transfer runs, SCK sits at the polarity bit.
- R4: With phase 0, MOSI carries the first bit before the first SCK edge, MISO is sampled on leading edges, and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: A transfer sends the written byte MSB first and captures 8 MISO bits MSB first. The holding register changes only at the end of a completed transfer, so a read during a transfer returns the previous byte.
- R6: The transfer-done flag is set in the cycle after the 16th SCK edge, when SCK is back at idle.
- R7: The done and collision flags are cleared by a status read that sees either flag set, followed by a data register read or write. A data access with no such status read first leaves the flags set.
- R8: A data write during a transfer is discarded, sets the collision flag, and does not disturb the running transfer.
- R9: A data write while enable or master select is 0 starts no transfer: SCK does not move and the done flag stays 0.
- R10: With enable and master select at 1 and slave-select disable at 0, a low slave-select input sets the mode fault flag, clears master select, and aborts any transfer without setting the done flag. A control register write clears the mode fault flag.
- R11: With slave-select disable at 1, the slave-select input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave-select input, used for mode-fault detection |

## Verification
The main exchange is run three ways: with MISO looped back to MOSI, with a pseudo-random MISO stream, and in all four polarity and phase combinations. Loopback shows whether sampling and driving land on opposite SCK edges, since only then does the byte return intact. The random stream separates bit order and the exact capture edge, because a half-clock shift changes the received value. Running the slowest code next to the reserved code and the two fastest codes shows whether the divider saturates and is latched at start. Collisions, reads during a transfer, and slave-select drops in the middle of a transfer show whether the running exchange and the holding register are left alone.

// File: rtl/spi_mr_pkg.sv
package spi_mr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STA = 2'd1;
  localparam logic [ADDR_W-1:0] A_DAT = 2'd2;

  // control register bit positions
  localparam int C_RHI = 7;
  localparam int C_EN  = 6;
  localparam int C_SSD = 5;
  localparam int C_MS  = 4;
  localparam int C_POL = 3;
  localparam int C_PHA = 2;

  // status register bit positions
  localparam int S_DONE = 7;
  localparam int S_WCOL = 6;
  localparam int S_MODF = 4;
endpackage

// File: rtl/spi_mr_bitclk.sv
module spi_mr_bitclk #(
  parameter int RATE_W = 3,
  parameter int NBITS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              cpol,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              sck,
  output logic              tick,
  output logic              lead,
  output logic              last
);
  localparam int MAX_SH = (1 << RATE_W) - 2;
  localparam int CNT_W  = MAX_SH + 1;
  localparam int EDGES  = 2 * NBITS;
  localparam int EI_W   = $clog2(EDGES);

  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_m1;
  logic [EI_W-1:0]   idx;

  always_comb begin
    if (rate_q > RATE_W'(MAX_SH))
      half_m1 = CNT_W'((1 << MAX_SH) - 1);
    else
      half_m1 = (CNT_W'(1) << rate_q) - CNT_W'(1);
  end

  assign tick = busy && (cnt == half_m1);
  assign lead = ~idx[0];
  assign last = (idx == EI_W'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      rate_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= cpol;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      idx    <= '0;
      rate_q <= rate;
      sck    <= cpol;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        sck <= ~sck;
        idx <= idx + EI_W'(1);
        if (last) busy <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_mr_shift.sv
module spi_mr_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  logic              tick,
  input  logic              lead,
  input  logic              last,
  input  logic              cpha,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] sh;
  logic sample, change;

  assign sample  = tick && (cpha ? !lead : lead);
  assign change  = tick && (cpha ? lead : !lead) && !last;
  assign rx_word = cpha ? {sh[DATA_W-2:0], miso} : sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      mosi <= 1'b0;
    end else if (start) begin
      sh   <= load;
      mosi <= load[DATA_W-1];
    end else begin
      if (sample) sh <= {sh[DATA_W-2:0], miso};
      if (change) mosi <= sh[DATA_W-1];
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_mr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_n_i
);
  localparam int RATE_W = 3;

  logic [DATA_W-1:0] ctl_q, rx_hold, rx_word, sta_w;
  logic [RATE_W-1:0] rate;
  logic spif, wcol, modf, armed;
  logic busy, tick, lead, last;
  logic active, fault, ctl_wr, sta_rd, dat_wr, dat_acc;
  logic start, collide, abort, done, clr;

  always_comb begin
    rate    = {ctl_q[C_RHI], ctl_q[1:0]};
    active  = ctl_q[C_EN] && ctl_q[C_MS];
    fault   = active && !ctl_q[C_SSD] && !ss_n_i;
    ctl_wr  = reg_wr && (reg_addr == A_CTL);
    sta_rd  = reg_rd && (reg_addr == A_STA);
    dat_wr  = reg_wr && (reg_addr == A_DAT);
    dat_acc = dat_wr || (reg_rd && (reg_addr == A_DAT));
    start   = dat_wr && active && !fault && !busy;
    collide = dat_wr && busy;
    abort   = busy && (fault || !active);
    done    = tick && last && !abort;
    clr     = dat_acc && armed;
    sta_w          = '0;
    sta_w[S_DONE]  = spif;
    sta_w[S_WCOL]  = wcol;
    sta_w[S_MODF]  = modf;
  end

  spi_mr_bitclk #(.RATE_W(RATE_W), .NBITS(DATA_W)) u_clk (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .cpol(ctl_q[C_POL]), .rate(rate), .busy(busy), .sck(sck_o),
    .tick(tick), .lead(lead), .last(last)
  );

  spi_mr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .load(reg_wdata),
    .tick(tick), .lead(lead), .last(last), .cpha(ctl_q[C_PHA]),
    .miso(miso_i), .mosi(mosi_o), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      rx_hold   <= '0;
      reg_rdata <= '0;
      spif      <= 1'b0;
      wcol      <= 1'b0;
      modf      <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          A_CTL:   reg_rdata <= ctl_q;
          A_STA:   reg_rdata <= sta_w;
          A_DAT:   reg_rdata <= rx_hold;
          default: reg_rdata <= '0;
        endcase
      end
      if (ctl_wr)     ctl_q       <= reg_wdata;
      else if (fault) ctl_q[C_MS] <= 1'b0;

      if (ctl_wr)     modf <= 1'b0;
      else if (fault) modf <= 1'b1;

      if (done) rx_hold <= rx_word;

      if (done)     spif <= 1'b1;
      else if (clr) spif <= 1'b0;

      if (collide)  wcol <= 1'b1;
      else if (clr) wcol <= 1'b0;

      if (dat_acc)                      armed <= 1'b0;
      else if (sta_rd && (spif || wcol)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk
  import spi_mr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] ctl_q,
  input logic              busy,
  input logic              spif,
  input logic              wcol,
  input logic              modf,
  input logic              sck_o,
  input logic              ss_n_i
);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(ctl_q[C_POL])) |-> (sck_o == ctl_q[C_POL]));

  assert_done_after_xfer_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(spif) |-> $past(busy));

  assert_collision_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_DAT && busy) |=> wcol);

  assert_no_xfer_inactive_R9: assert property (@(posedge clk) disable iff (rst)
    !(ctl_q[C_EN] && ctl_q[C_MS]) |=> !busy);

  assert_mode_fault_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[C_EN] && ctl_q[C_MS] && !ctl_q[C_SSD] && !ss_n_i &&
     !(reg_wr && reg_addr == A_CTL)) |=> (modf && !ctl_q[C_MS] && !busy));

  assert_ss_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    ctl_q[C_SSD] |=> !$rose(modf));
endmodule

bind spi_master_regs spi_master_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctl_q(ctl_q), .busy(busy), .spif(spif), .wcol(wcol), .modf(modf),
  .sck_o(sck_o), .ss_n_i(ss_n_i)
);

// File: tb/sim_spi_master_regs.sv
`timescale 1ns/1ps
module sim_spi_master_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sck_o, mosi_o, miso_i;
  logic ss_n_i = 1'b1;
  logic loopback = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  assign miso_i = loopback ? mosi_o : lfsr[0];

  always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

  spi_master_regs u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctl, m_rx, m_rdata, m_tx, m_rxacc;
  int m_spif, m_wcol, m_modf, m_arm, m_sck, m_mosi, m_busy, m_rdv;
  int m_tick, m_half, m_edge, m_txi;

  always @(posedge clk) begin
    int active, fault, dat_wr, dat_acc, sta_rd, ctl_wr, start, collide, abort, done, clr;
    int cpol, cpha, code, lead, samp;
    if (rst) begin
      m_ctl = 0; m_rx = 0; m_rdata = 0; m_tx = 0; m_rxacc = 0;
      m_spif = 0; m_wcol = 0; m_modf = 0; m_arm = 0; m_sck = 0; m_mosi = 0;
      m_busy = 0; m_rdv = 0; m_tick = 0; m_half = 1; m_edge = 0; m_txi = 0;
    end else begin
      m_rdv = reg_rd;
      if (reg_rd) begin
        if (reg_addr == 0) m_rdata = m_ctl;
        else if (reg_addr == 1) m_rdata = 8'((m_spif << 7) | (m_wcol << 6) | (m_modf << 4));
        else if (reg_addr == 2) m_rdata = m_rx;
        else m_rdata = 0;
      end
      cpol = m_ctl[3]; cpha = m_ctl[2];
      active  = m_ctl[6] && m_ctl[4];
      fault   = active && !m_ctl[5] && !ss_n_i;
      ctl_wr  = reg_wr && reg_addr == 0;
      sta_rd  = reg_rd && reg_addr == 1;
      dat_wr  = reg_wr && reg_addr == 2;
      dat_acc = dat_wr || (reg_rd && reg_addr == 2);
      start   = dat_wr && active && !fault && !m_busy;
      collide = dat_wr && m_busy;
      abort   = m_busy && (fault || !active);
      clr     = dat_acc && m_arm;
      done    = 0;
      if (abort) begin
        m_busy = 0; m_sck = cpol;
      end else if (start) begin
        code = {m_ctl[7], m_ctl[1:0]};
        if (code > 6) code = 6;
        m_half = 1 << code;
        m_busy = 1; m_tick = 0; m_edge = 0; m_tx = reg_wdata;
        m_mosi = reg_wdata[7]; m_txi = cpha ? 7 : 6; m_rxacc = 0; m_sck = cpol;
      end else if (m_busy) begin
        if (m_tick == m_half - 1) begin
          m_tick = 0;
          m_sck = !m_sck;
          lead = (m_edge % 2 == 0);
          samp = cpha ? !lead : lead;
          if (samp) m_rxacc = {m_rxacc[6:0], miso_i};
          else if (m_edge != 15) begin
            m_mosi = m_tx[m_txi];
            m_txi--;
          end
          if (m_edge == 15) begin
            m_busy = 0; done = 1; m_rx = m_rxacc;
          end
          m_edge++;
        end else m_tick++;
      end else m_sck = cpol;

      if (done) m_spif = 1; else if (clr) m_spif = 0;
      if (collide) m_wcol = 1; else if (clr) m_wcol = 0;
      if (dat_acc) m_arm = 0; else if (sta_rd && (m_spif_old_or(m_spif, m_wcol, done, collide, clr))) m_arm = 1;
      if (ctl_wr) m_modf = 0; else if (fault) m_modf = 1;
      if (ctl_wr) m_ctl = reg_wdata; else if (fault) m_ctl[4] = 1'b0;
    end
  end

  // arming uses the flag values seen by the status read, i.e. before this cycle's update
  function automatic int m_spif_old_or(input int s_new, input int w_new, input int dn,
                                       input int col, input int cl);
    int s_old, w_old;
    s_old = dn ? prev_spif : s_new;
    w_old = col ? prev_wcol : w_new;
    if (cl) begin s_old = prev_spif; w_old = prev_wcol; end
    return (s_old != 0) || (w_old != 0);
  endfunction

  int prev_spif, prev_wcol;
  always @(negedge clk) begin
    prev_spif <= m_spif;
    prev_wcol <= m_wcol;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 sck_o vs model", sck_o, m_sck);
      chk("R4 mosi_o vs model", mosi_o, m_mosi);
      if (m_rdv) chk("R2 reg_rdata vs model", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && m_busy != 0; i++) @(negedge clk);
  endtask

  logic [7:0] v;
  int moves, per;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 sck after reset", sck_o, 0);
    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    rd(2'd2, v); chk("R1 holding reset", v, 8'h00);

    // R5/R6 loopback exchange, fastest rate, mode 0
    wr(2'd0, 8'h50);
    wr(2'd2, 8'hA5);
    wait_idle();
    rd(2'd1, v); chk("R6 done flag after transfer", v, 8'h80);
    rd(2'd2, v); chk("R5 loopback byte", v, 8'hA5);
    rd(2'd1, v); chk("R7 flags cleared by status then data", v, 8'h00);

    // R7 data access without preceding status read does not clear
    wr(2'd2, 8'h3C);
    wait_idle();
    rd(2'd2, v); chk("R5 second loopback byte", v, 8'h3C);
    rd(2'd1, v); chk("R7 done flag kept without status read", v, 8'h80);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 done flag cleared", v, 8'h00);

    // R3/R4/R5 all modes with random MISO
    loopback = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int r = 1; r < 3; r++) begin
        wr(2'd0, 8'(8'h50 | (m << 2) | r));
        wr(2'd2, 8'(8'h1B + 37 * m + r));
        wait_idle();
        rd(2'd1, v); chk("R6 done in mode sweep", v, 8'h80);
        rd(2'd2, v); chk("R5 received byte vs model", v, m_rx);
      end
    end

    // R3 slowest code and reserved code: half period of 64 clocks
    wr(2'd0, 8'hD2);
    wr(2'd2, 8'h81);
    wait_idle();
    wr(2'd0, 8'hDB);
    wr(2'd2, 8'h42);
    for (int i = 0; i < 200 && sck_o == 1'b1; i++) @(negedge clk);
    per = 0;
    for (int i = 0; i < 200 && sck_o == 1'b0; i++) begin @(negedge clk); per++; end
    chk("R3 reserved code half period", per, 64);
    wait_idle();
    rd(2'd1, v);
    rd(2'd2, v); chk("R5 received byte at reserved rate", v, m_rx);

    // R8 collision
    loopback = 1'b1;
    wr(2'd0, 8'h51);
    wr(2'd2, 8'h96);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h11);
    wait_idle();
    rd(2'd1, v); chk("R8 collision and done flags", v, 8'hC0);
    rd(2'd2, v); chk("R8 running transfer undisturbed", v, 8'h96);

    // R5 holding register during transfer
    wr(2'd0, 8'h52);
    wr(2'd2, 8'h5A);
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk("R5 hold during transfer", v, 8'h96);
    wait_idle();
    rd(2'd2, v); chk("R5 hold after transfer", v, 8'h5A);
    rd(2'd1, v);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 flags cleared before R9", v, 8'h00);

    // R9 not master
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h77);
    moves = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck_o !== 1'b0) moves++; end
    chk("R9 no SCK activity", moves, 0);
    rd(2'd1, v); chk("R9 no done flag", v, 8'h00);

    // R10 mode fault aborts transfer
    wr(2'd0, 8'h52);
    wr(2'd2, 8'hF0);
    repeat (10) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (2) @(negedge clk);
    ss_n_i = 1'b1;
    chk("R10 SCK idle after abort", sck_o, 0);
    rd(2'd0, v); chk("R10 master select cleared", v, 8'h42);
    rd(2'd1, v); chk("R10 mode fault without done", v, 8'h10);
    wr(2'd0, 8'h52);
    rd(2'd1, v); chk("R10 mode fault cleared by control write", v, 8'h00);

    // R11 slave-select disabled
    wr(2'd0, 8'h72);
    ss_n_i = 1'b0;
    wr(2'd2, 8'h0F);
    wait_idle();
    ss_n_i = 1'b1;
    rd(2'd1, v); chk("R11 no mode fault", v, 8'h80);
    rd(2'd2, v); chk("R11 transfer completed", v, 8'h0F);
    rd(2'd0, v); chk("R11 control unchanged", v, 8'h72);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule